// File: doc/BRIEF.md
# Timer Event Request Router

This block sits between four 8-bit down-counting timers and the rest of the chip. Each timer produces a one-cycle underflow pulse. The block latches every pulse into a per-timer event flag. It then steers the pending event to one of two places: a CPU interrupt request, or a request to the intelligent DMA engine. A per-timer route-select bit chooses the path. A per-timer DMA gate bit must also be set before a DMA request can leave the block.

Software reaches the flags and control bits through a small synchronous register port with a 2-bit address, a write strobe, write data and combinational read data. A global write-mode bit sets how writes of 0 behave on the select and gate bits. In set-only mode, which is the reset default, a 0 written to a bit does nothing. In read/write mode, a 0 clears the bit. When the DMA engine has serviced a timer, it pulses that timer's done input. This clears the route-select bit, so later events from that timer go back to the interrupt path.

All pins are plain level or pulse signals sampled on the rising clock edge. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure. A register access takes exactly one cycle with the strobe high.

Top module: `timer_req_router`

## Requirements
- R1: After reset, the flag, select, gate and mode registers all read 0, and every interrupt and DMA request output is low.
- R2: For timer i, irq_req[i] is high exactly when flag i is set and select bit i is 0.
- R3: For timer i, dma_req[i] is high exactly when flag i, select bit i and gate bit i are all set.
- R4: When mode bit 0 (address 3) is 0, a write to the select register (address 1, bits 0..3) or the gate register sets each bit that is written as 1 and leaves each bit written as 0 unchanged.
- R5: When mode bit 0 is 1, a write to the select or gate register loads the written value, so a 0 clears the bit.
- R6: The gate bits for timers 0..3 sit at bits 2..5 of address 2. The other bit positions of that address read 0, and writes to them change no gate bit.
- R7: The flag register is at address 0, bits 0..3. An underflow pulse sets its flag at the next clock edge. A write of 1 clears a flag, and a write of 0 leaves it alone, in either mode.
- R8: A set flag stays set, and its request stays asserted, until software clears it.
- R9: When an underflow pulse and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: A dma_done pulse clears that timer's select bit at the next edge. It overrides a same-cycle write that sets the bit.
- R11: Read data is combinational from reg_addr. Address 3 returns the mode in bit 0 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ufl_pulse | input | 4 | Underflow pulse per timer |
| dma_done | input | 4 | Per-timer DMA service-complete pulse |
| reg_addr | input | 2 | Register address (0 flags, 1 select, 2 gate, 3 mode) |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_req | output | 4 | Per-timer interrupt request |
| dma_req | output | 4 | Per-timer DMA request |

## Verification
The assertions assume that every input is synchronous to clk and settles before each rising edge. They also assume a register write lasts exactly one strobed cycle. The properties compare flag and select state across one edge, so the bench changes its inputs only on falling edges and holds reg_wr for a single cycle per access. The collision and done-override properties only say something when pulses and writes coincide. The bench therefore drives those coincidences on purpose, as well as the isolated cases.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_SEL  = 2'd1,
    RA_GATE = 2'd2,
    RA_MODE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tr_ctl_bits.sv
// Control bit group with a selectable write discipline and a hardware clear.
module tr_ctl_bits #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rw_mode,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] written;

  always_comb begin
    written = q;
    if (wr_en) written = rw_mode ? wdata : (q | wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= written & ~hw_clr;
  end

  // R4
  set_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_mode && hw_clr == '0) |=> ((q & $past(q)) == $past(q)));

  // R10
  hw_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr != '0) |=> ((q & $past(hw_clr)) == '0));
endmodule

// File: rtl/tr_flag_bank.sv
// Per-timer event flags: set by underflow, cleared by writing 1, event wins.
module tr_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~sw_clr) | evt;
  end

  // R7
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((q & $past(evt)) == $past(evt)));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(q) & ~$past(sw_clr)) & ~q) == '0));
endmodule

// File: rtl/tr_route.sv
// Steers each pending flag to the interrupt or the DMA request output.
module tr_route #(
  parameter int N = 4
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] gate,
  output logic [N-1:0] irq,
  output logic [N-1:0] dma
);
  for (genvar i = 0; i < N; i++) begin : g_path
    assign irq[i] = flag[i] & ~sel[i];
    assign dma[i] = flag[i] & sel[i] & gate[i];

    // R2
    always_comb begin
      excl_path_chk: assert (!(irq[i] && dma[i]));
    end
  end
endmodule

// File: rtl/timer_req_router.sv
module timer_req_router #(
  parameter int N_TMR   = 4,
  parameter int DW      = 8,
  parameter int GATE_LO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] ufl_pulse,
  input  logic [N_TMR-1:0] dma_done,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [N_TMR-1:0] irq_req,
  output logic [N_TMR-1:0] dma_req
);
  import tr_pkg::*;

  localparam int GATE_HI = GATE_LO + N_TMR - 1;

  reg_addr_e   addr;
  logic [N_TMR-1:0] flag_q, sel_q, gate_q, sw_clr;
  logic        mode_q;
  logic        wr_flag, wr_sel, wr_gate, wr_mode;

  assign addr    = reg_addr_e'(reg_addr);
  assign wr_flag = reg_wr && (addr == RA_FLAG);
  assign wr_sel  = reg_wr && (addr == RA_SEL);
  assign wr_gate = reg_wr && (addr == RA_GATE);
  assign wr_mode = reg_wr && (addr == RA_MODE);
  assign sw_clr  = wr_flag ? reg_wdata[N_TMR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (wr_mode) mode_q <= reg_wdata[0];
  end

  tr_flag_bank #(.N(N_TMR)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(ufl_pulse), .sw_clr(sw_clr), .q(flag_q)
  );

  tr_ctl_bits #(.W(N_TMR)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sel), .rw_mode(mode_q),
    .wdata(reg_wdata[N_TMR-1:0]), .hw_clr(dma_done), .q(sel_q)
  );

  tr_ctl_bits #(.W(N_TMR)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_gate), .rw_mode(mode_q),
    .wdata(reg_wdata[GATE_HI:GATE_LO]), .hw_clr({N_TMR{1'b0}}), .q(gate_q)
  );

  tr_route #(.N(N_TMR)) u_route (
    .flag(flag_q), .sel(sel_q), .gate(gate_q), .irq(irq_req), .dma(dma_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (addr)
      RA_FLAG: reg_rdata[N_TMR-1:0]     = flag_q;
      RA_SEL:  reg_rdata[N_TMR-1:0]     = sel_q;
      RA_GATE: reg_rdata[GATE_HI:GATE_LO] = gate_q;
      default: reg_rdata[0]             = mode_q;
    endcase
  end

  // R3
  dma_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_req & ~gate_q) == '0));

  // R9
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ufl_pulse & sw_clr) != '0) |=> ((flag_q & $past(ufl_pulse)) == $past(ufl_pulse)));

  // R6
  gate_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gate && reg_wdata[GATE_HI:GATE_LO] == '0 && !mode_q) |=> $stable(gate_q));
endmodule

// File: tb/timer_req_router_test.sv
module timer_req_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ufl_pulse = '0;
  logic [3:0] dma_done = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] irq_req, dma_req;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  timer_req_router uut (
    .clk(clk), .rst_n(rst_n), .ufl_pulse(ufl_pulse), .dma_done(dma_done),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .dma_req(dma_req)
  );

  // {select, gate, events, expected irq, expected dma}
  localparam logic [19:0] VEC [8] = '{
    {4'h0, 4'h0, 4'hF, 4'hF, 4'h0},
    {4'hF, 4'h0, 4'hF, 4'h0, 4'h0},
    {4'hF, 4'hF, 4'hF, 4'h0, 4'hF},
    {4'h5, 4'h3, 4'hF, 4'hA, 4'h1},
    {4'hA, 4'hF, 4'h6, 4'h4, 4'h2},
    {4'hC, 4'h6, 4'h9, 4'h1, 4'h0},
    {4'h3, 4'h2, 4'h3, 4'h0, 4'h2},
    {4'h9, 4'h9, 4'hE, 4'h6, 4'h8}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    ufl_pulse = e;
    @(negedge clk);
    ufl_pulse = '0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 8'h00);
    end
    chk("R1 outs", {irq_req, dma_req}, 8'h00);

    // R11 mode reads in bit 0 only; switch to read/write for the table
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R11 mode", d, 8'h01);

    // R2 R3 routing table
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, {4'h0, VEC[k][19:16]});
      wr(2'd2, {2'b00, VEC[k][15:12], 2'b00});
      wr(2'd0, 8'h0F);
      pulse(VEC[k][11:8]);
      #1;
      chk("R2 irq", {4'h0, irq_req}, {4'h0, VEC[k][7:4]});
      chk("R3 dma", {4'h0, dma_req}, {4'h0, VEC[k][3:0]});
    end

    // R5 read/write mode loads zeros
    wr(2'd1, 8'h02);
    rd(2'd1, d); chk("R5 sel", d, 8'h02);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R5 gate", d, 8'h00);

    // R4 set-only mode
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h05);
    rd(2'd1, d); chk("R4 sel or", d, 8'h07);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R4 sel hold", d, 8'h07);
    wr(2'd2, 8'h24);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R4 gate hold", d, 8'h24);

    // R6 other bit positions of the gate address
    wr(2'd2, 8'hC3);
    rd(2'd2, d); chk("R6 gate", d, 8'h24);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hC3);
    rd(2'd2, d); chk("R6 rw gate", d, 8'h00);

    // R7 flag clear by writing 1, zero ignored
    wr(2'd0, 8'h0F);
    pulse(4'hF);
    wr(2'd0, 8'h05);
    rd(2'd0, d); chk("R7 w1c", d, 8'h0A);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R7 w0", d, 8'h0A);

    // R8 request persists
    wr(2'd1, 8'h00);
    repeat (5) @(negedge clk);
    #1 chk("R8 hold", {4'h0, irq_req}, 8'h0A);

    // R9 event beats clear
    wr(2'd0, 8'h0F);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h01; reg_wr = 1'b1; ufl_pulse = 4'h1;
    @(negedge clk);
    reg_wr = 1'b0; ufl_pulse = '0;
    rd(2'd0, d); chk("R9 collide", d, 8'h01);

    // R10 dma_done returns to interrupt path
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h04);
    #1 chk("R10 dma before", {dma_req, irq_req}, 8'h10);
    @(negedge clk);
    dma_done = 4'h1;
    @(negedge clk);
    dma_done = '0;
    #1 chk("R10 after", {dma_req, irq_req}, 8'h01);
    // R10 done overrides a same-cycle set
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 8'h03; reg_wr = 1'b1; dma_done = 4'h1;
    @(negedge clk);
    reg_wr = 1'b0; dma_done = '0;
    rd(2'd1, d); chk("R10 override", d, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule